// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block decides, cycle by cycle, which clocks of a small microcontroller may run. It reads four power-control bits from the CPU status word and two pieces of interrupt state: an asynchronous wakeup request and a flag that is high while an interrupt handler runs. From these it drives two glitch-free gated copies of the fast oscillator clock, one for the CPU and one for the sub-main clock tree. It also drives run enables for the fast oscillator and for the low-frequency crystal branch.

Any interrupt activity overrides every power bit, so all clocks run while the request is pending and while the handler runs. Once the handler returns, the status bits it restored take effect again. If they are still set, the clocks stop again. If the handler cleared them, the part stays awake. The wakeup request passes through a two-flop synchronizer clocked by the free-running oscillator input, so it still works while the CPU clock is stopped. The synchronized request is also presented as the interrupt request line.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After the synchronous reset, every clock runs: `fast_osc_en` = 1, `lf_osc_en` = 1, `irq_req` = 0, and both gated clocks pulse.
- R2: With `sr_pwr[0]` (CPU halt) = 1 and no interrupt activity, `mclk_g` gives no rising edge, starting with the second `osc_clk` edge after the bit is sampled.
- R3: With `sr_pwr[3]` (sub-main off) = 1, `SUB_GATE_EN` = 1 and no interrupt activity, `smclk_g` gives no rising edge.
- R4: With `sr_pwr[2]` (fast oscillator off) = 1 and no interrupt activity, `fast_osc_en` is 0 one `osc_clk` edge later.
- R5: With `sr_pwr[1]` (crystal off) = 1, `LF_GATE_EN` = 1 and no interrupt activity, `lf_osc_en` is 0 one `osc_clk` edge later.
- R6: A clock that is not gated gives exactly one rising edge per `osc_clk` cycle.
- R7: While `isr_active` = 1, all four run controls are on one edge later, whatever the status bits are.
- R8: While `irq_req` = 1, all four run controls are on one edge later, whatever the status bits are.
- R9: After `isr_active` falls, the current status bits apply again: bits that are still set stop their clocks, and cleared bits leave them running.
- R10: `irq_req` follows `wake_req` after exactly two `osc_clk` edges, and reset clears it.
- R11: When `SUB_GATE_EN` = 0, `sr_pwr[3]` has no effect on `smclk_g`. When `LF_GATE_EN` = 0, `sr_pwr[1]` has no effect on `lf_osc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running fast oscillator clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sr_pwr | input | 4 | Status power bits: [0] CPU halt, [1] crystal off, [2] fast oscillator off, [3] sub-main off |
| wake_req | input | 1 | Asynchronous wakeup request |
| isr_active | input | 1 | High while an interrupt handler runs |
| mclk_g | output | 1 | Gated CPU clock |
| smclk_g | output | 1 | Gated sub-main clock |
| fast_osc_en | output | 1 | Run enable for the fast oscillator |
| lf_osc_en | output | 1 | Run enable for the crystal branch |
| irq_req | output | 1 | Synchronized wakeup, used as the interrupt request |

## Verification
The assertions assume that `sr_pwr` and `isr_active` are synchronous to `osc_clk` and are stable around its rising edge. They also assume that `osc_clk` keeps toggling, even when `fast_osc_en` is low. The stimulus changes every input only on the falling edge of `osc_clk`, and the clock runs all the time. `wake_req` is treated as asynchronous by the design, but the bench still drives it on the falling edge so that the two-edge latency can be counted exactly.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Status power bits, in the order the status word holds them.
    typedef struct packed {
        logic sub_off;
        logic fast_off;
        logic lf_off;
        logic cpu_off;
    } lpm_bits_t;

    // Run controls, one per clock branch.
    typedef struct packed {
        logic sub;
        logic fast;
        logic lf;
        logic cpu;
    } lpm_run_t;

    localparam int unsigned GATED_CLKS = 2;
    localparam lpm_run_t    RUN_ALL    = lpm_run_t'(4'hF);

    function automatic lpm_run_t resolve_run(
        input lpm_bits_t b,
        input logic      override,
        input logic      sub_gate_en,
        input logic      lf_gate_en
    );
        lpm_run_t r;
        if (override) begin
            r = RUN_ALL;
        end else begin
            r.cpu  = !b.cpu_off;
            r.fast = !b.fast_off;
            r.sub  = !(b.sub_off && sub_gate_en);
            r.lf   = !(b.lf_off && lf_gate_en);
        end
        return r;
    endfunction

endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // R10: a rising output needs the input seen two edges earlier
    assert_sync_latency_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_out) |-> $past(async_in, 2));

    assert_sync_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_out) |-> !$past(async_in, 2));

endmodule

// File: rtl/lpm_mode_ctrl.sv
module lpm_mode_ctrl
    import lpm_pkg::*;
#(
    parameter bit SUB_GATE_EN = 1'b1,
    parameter bit LF_GATE_EN  = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  lpm_bits_t pwr_bits,
    input  logic      isr_active,
    input  logic      irq_req,
    output lpm_run_t  run_q
);
    logic     wake_override;
    lpm_run_t run_d;

    assign wake_override = isr_active | irq_req;

    always_comb begin
        run_d = resolve_run(pwr_bits, wake_override, SUB_GATE_EN, LF_GATE_EN);
    end

    always_ff @(posedge clk) begin
        if (rst) run_q <= RUN_ALL;
        else     run_q <= run_d;
    end

    assert_isr_all_run_R7: assert property (@(posedge clk) disable iff (rst)
        isr_active |=> (run_q == RUN_ALL));

    assert_irq_all_run_R8: assert property (@(posedge clk) disable iff (rst)
        irq_req |=> (run_q == RUN_ALL));

    assert_cpu_halt_R2: assert property (@(posedge clk) disable iff (rst)
        (pwr_bits.cpu_off && !isr_active && !irq_req) |=> !run_q.cpu);

    assert_fast_halt_R4: assert property (@(posedge clk) disable iff (rst)
        (pwr_bits.fast_off && !isr_active && !irq_req) |=> !run_q.fast);

    assert_restore_run_R9: assert property (@(posedge clk) disable iff (rst)
        (!pwr_bits.cpu_off && !pwr_bits.fast_off) |=> (run_q.cpu && run_q.fast));

    generate
        if (SUB_GATE_EN) begin : g_sub_gate
            assert_sub_halt_R3: assert property (@(posedge clk) disable iff (rst)
                (pwr_bits.sub_off && !isr_active && !irq_req) |=> !run_q.sub);
        end else begin : g_sub_fixed
            assert_sub_ignored_R11: assert property (@(posedge clk) disable iff (rst)
                pwr_bits.sub_off |=> run_q.sub);
        end
        if (LF_GATE_EN) begin : g_lf_gate
            assert_lf_halt_R5: assert property (@(posedge clk) disable iff (rst)
                (pwr_bits.lf_off && !isr_active && !irq_req) |=> !run_q.lf);
        end else begin : g_lf_fixed
            assert_lf_ignored_R11: assert property (@(posedge clk) disable iff (rst)
                pwr_bits.lf_off |=> run_q.lf);
        end
    endgenerate

endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);
    logic en_lat;

    // Enable passes only while the clock is low.
    always_latch begin
        if (!clk_in) en_lat = en;
    end

    assign clk_out = clk_in & en_lat;

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter bit SUB_GATE_EN = 1'b1,
    parameter bit LF_GATE_EN  = 1'b1
) (
    input  logic       osc_clk,
    input  logic       rst,
    input  logic [3:0] sr_pwr,
    input  logic       wake_req,
    input  logic       isr_active,
    output logic       mclk_g,
    output logic       smclk_g,
    output logic       fast_osc_en,
    output logic       lf_osc_en,
    output logic       irq_req
);
    lpm_run_t                run_q;
    logic [GATED_CLKS-1:0]   gate_en;
    logic [GATED_CLKS-1:0]   gate_out;

    lpm_wake_sync u_sync (
        .clk      (osc_clk),
        .rst      (rst),
        .async_in (wake_req),
        .sync_out (irq_req)
    );

    lpm_mode_ctrl #(
        .SUB_GATE_EN (SUB_GATE_EN),
        .LF_GATE_EN  (LF_GATE_EN)
    ) u_mode (
        .clk        (osc_clk),
        .rst        (rst),
        .pwr_bits   (lpm_bits_t'(sr_pwr)),
        .isr_active (isr_active),
        .irq_req    (irq_req),
        .run_q      (run_q)
    );

    assign gate_en = {run_q.sub, run_q.cpu};

    genvar gi;
    generate
        for (gi = 0; gi < GATED_CLKS; gi++) begin : g_gate
            lpm_clk_gate u_gate (
                .clk_in  (osc_clk),
                .en      (gate_en[gi]),
                .clk_out (gate_out[gi])
            );
        end
    endgenerate

    assign mclk_g      = gate_out[0];
    assign smclk_g     = gate_out[1];
    assign fast_osc_en = run_q.fast;
    assign lf_osc_en   = run_q.lf;

    // R1: reset leaves every branch running
    assert_reset_run_R1: assert property (@(posedge osc_clk)
        $past(rst) |-> (fast_osc_en && lf_osc_en && !irq_req));

endmodule

// File: tb/lpm_clk_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_clk_ctrl_bench;
    logic       osc_clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] sr_pwr = 4'h0;
    logic       wake_req = 1'b0;
    logic       isr_active = 1'b0;
    logic       mclk_g, smclk_g, fast_osc_en, lf_osc_en, irq_req;
    logic       mclk_f, smclk_f, fast_f, lf_f, irq_f;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0, s_cnt = 0, sf_cnt = 0;
    int m_res, s_res, sf_res;
    localparam int WIN = 16;

    always #10 osc_clk = ~osc_clk;

    lpm_clk_ctrl u_lpm_clk_ctrl (
        .osc_clk(osc_clk), .rst(rst), .sr_pwr(sr_pwr), .wake_req(wake_req),
        .isr_active(isr_active), .mclk_g(mclk_g), .smclk_g(smclk_g),
        .fast_osc_en(fast_osc_en), .lf_osc_en(lf_osc_en), .irq_req(irq_req));

    lpm_clk_ctrl #(.SUB_GATE_EN(1'b0), .LF_GATE_EN(1'b0)) u_lpm_clk_ctrl_fixed (
        .osc_clk(osc_clk), .rst(rst), .sr_pwr(sr_pwr), .wake_req(wake_req),
        .isr_active(isr_active), .mclk_g(mclk_f), .smclk_g(smclk_f),
        .fast_osc_en(fast_f), .lf_osc_en(lf_f), .irq_req(irq_f));

    always @(posedge mclk_g)  m_cnt++;
    always @(posedge smclk_g) s_cnt++;
    always @(posedge smclk_f) sf_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge osc_clk);
    endtask

    task automatic window();
        m_cnt = 0; s_cnt = 0; sf_cnt = 0;
        step(WIN);
        m_res = m_cnt; s_res = s_cnt; sf_res = sf_cnt;
    endtask

    task automatic t_reset();
        step(3);
        rst = 1'b0;
        step(1);
        check("R1 fast_osc_en", fast_osc_en, 1);
        check("R1 lf_osc_en", lf_osc_en, 1);
        check("R1 irq_req", irq_req, 0);
        step(2);
        window();
        check("R1/R6 mclk edges", m_res, WIN);
        check("R1/R6 smclk edges", s_res, WIN);
    endtask

    task automatic t_cpu_halt();
        sr_pwr = 4'b0001;
        step(3);
        window();
        check("R2 mclk stopped", m_res, 0);
        check("R6 smclk running", s_res, WIN);
        sr_pwr = 4'b0000;
        step(3);
        window();
        check("R6 mclk resumed", m_res, WIN);
    endtask

    task automatic t_sub_off();
        sr_pwr = 4'b1000;
        step(3);
        window();
        check("R3 smclk stopped", s_res, 0);
        check("R11 smclk ungated variant", sf_res, WIN);
        check("R6 mclk running", m_res, WIN);
        sr_pwr = 4'b0000;
        step(3);
    endtask

    task automatic t_osc_bits();
        sr_pwr = 4'b0100;
        step(1);
        check("R4 fast_osc_en off", fast_osc_en, 0);
        check("R4 lf_osc_en untouched", lf_osc_en, 1);
        sr_pwr = 4'b0010;
        step(1);
        check("R5 lf_osc_en off", lf_osc_en, 0);
        check("R5 fast_osc_en back", fast_osc_en, 1);
        check("R11 lf ungated variant", lf_f, 1);
        sr_pwr = 4'b0000;
        step(2);
    endtask

    task automatic t_isr();
        sr_pwr = 4'hF;
        step(3);
        isr_active = 1'b1;
        step(1);
        check("R7 fast_osc_en forced", fast_osc_en, 1);
        check("R7 lf_osc_en forced", lf_osc_en, 1);
        step(2);
        window();
        check("R7 mclk forced", m_res, WIN);
        check("R7 smclk forced", s_res, WIN);
        isr_active = 1'b0;
        step(3);
        window();
        check("R9 mclk stops again", m_res, 0);
        check("R9 fast_osc_en off again", fast_osc_en, 0);
        isr_active = 1'b1;
        step(2);
        sr_pwr = 4'h0;
        step(1);
        isr_active = 1'b0;
        step(3);
        window();
        check("R9 mclk stays on", m_res, WIN);
        check("R9 smclk stays on", s_res, WIN);
        check("R9 lf_osc_en stays on", lf_osc_en, 1);
    endtask

    task automatic t_wake();
        sr_pwr = 4'hF;
        step(3);
        wake_req = 1'b1;
        step(1);
        check("R10 irq_req after one edge", irq_req, 0);
        step(1);
        check("R10 irq_req after two edges", irq_req, 1);
        step(2);
        window();
        check("R8 mclk forced", m_res, WIN);
        check("R8 fast_osc_en forced", fast_osc_en, 1);
        rst = 1'b1;
        step(1);
        check("R10 reset clears irq_req", irq_req, 0);
        wake_req = 1'b0;
        sr_pwr = 4'h0;
        step(2);
        rst = 1'b0;
        step(2);
        wake_req = 1'b1;
        step(2);
        wake_req = 1'b0;
        step(1);
        check("R10 irq_req holds one more edge", irq_req, 1);
        step(1);
        check("R10 irq_req falls", irq_req, 0);
    endtask

    initial begin
        #(100000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_cpu_halt();
        t_sub_off();
        t_osc_bits();
        t_isr();
        t_wake();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule